// File: doc/BRIEF.md
# Shared Flag Word with Peer Interrupt Decode

This block holds one 16-bit flag word shared by up to seven processing units on a common bus. A unit that has been granted the bus reads or writes the whole word through a request channel. Read data comes back on a separate response channel. Most of the word carries control and interrupt bits that the block only stores. A 3-bit message field at bits [15:13] lets one unit signal another: each unit has a decoder that compares the field with its own logical number.

When a write changes the field to a unit's number, that unit's non-maskable interrupt line pulses for one cycle. Code 000 addresses nobody. The receiving unit clears the field by writing 000. Writing the same code again does not fire the interrupt a second time. This way one pending message cannot raise repeated interrupts while the other bits of the word are being updated.

The request channel uses valid/ready. A request is taken on a clock edge where both are high. `req_ready` drops only while a read response is waiting and `rsp_ready` is low, so a stalled reader holds up all further accesses. A read response rises the cycle after its request is accepted. It keeps its data stable until the response is taken by `rsp_valid && rsp_ready`.

Top module: `flagreg_ipi`

## Requirements
- R1: After reset the flag word reads 0x0000, every interrupt line is low, `rsp_valid` is low and `req_ready` is high.
- R2: An accepted write (`req_valid`, `req_ready` and `req_we` high at a clock edge) replaces all 16 bits of the flag word, and a later read returns the written value.
- R3: An accepted read (`req_we` low) raises `rsp_valid` in the next cycle with the flag word as it was at acceptance; `rsp_valid` and `rsp_rdata` hold unchanged until a clock edge with `rsp_ready` high.
- R4: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low; otherwise `req_ready` is high.
- R5: The message field is bits [15:13]. When an accepted write changes the field from any other value to code k (1..7, k not above the unit count), interrupt line k-1 is high for exactly the one cycle after the accepting edge.
- R6: An accepted write that leaves the message field at its current value raises no interrupt line, whatever it writes to the other bits.
- R7: Writing code 000 into the field clears it and raises no interrupt line.
- R8: At most one interrupt line is high in any cycle.
- R9: A read leaves the flag word unchanged and raises no interrupt line.
- R10: Inputs presented while `req_valid` is low have no effect on the flag word or on the interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Word to store on a write |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Reader takes the read data |
| rsp_rdata | output | 16 | Flag word returned by a read |
| ipi_nmi | output | 7 | One non-maskable interrupt pulse line per unit; bit k-1 belongs to unit k |

## Verification
A wrong stored word shows up on the next read response, which appears one cycle after the read is accepted. A wrong copy of the message field shows up sooner, on the interrupt lines in the cycle right after the next write. It appears as a missing pulse, a pulse on the wrong line, or a second pulse for a code that was already present. A stuck response register shows up at once as `req_ready` staying low or as read data that changes while the reader is stalled.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
  localparam int unsigned FLAG_W_DEF   = 16;
  localparam int unsigned CODE_W_DEF   = 3;
  localparam int unsigned CODE_LSB_DEF = 13;
  localparam int unsigned UNITS_DEF    = 7;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bus_op_e;
endpackage

// File: rtl/flagreg_bus_port.sv
module flagreg_bus_port
  import flagreg_pkg::*;
#(
  parameter int unsigned DATA_W = FLAG_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] flag_word,
  output bus_op_e           op,
  output logic [DATA_W-1:0] wr_data
);
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              accept;

  // one read may be outstanding; draining it frees the slot in the same cycle
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    op = OP_IDLE;
    if (accept) op = req_we ? OP_WRITE : OP_READ;
  end

  assign wr_data = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (op == OP_READ) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= flag_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
endmodule

// File: rtl/flagreg_store.sv
module flagreg_store
  import flagreg_pkg::*;
#(
  parameter int unsigned DATA_W   = FLAG_W_DEF,
  parameter int unsigned CODE_W   = CODE_W_DEF,
  parameter int unsigned CODE_LSB = CODE_LSB_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_op_e           op,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] flag_word,
  output logic              wr_en,
  output logic [CODE_W-1:0] code_cur,
  output logic [CODE_W-1:0] code_new
);
  logic [DATA_W-1:0] flag_q;

  assign wr_en = (op == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= '0;
    else if (wr_en) flag_q <= wr_data;
  end

  assign flag_word = flag_q;
  assign code_cur  = flag_q[CODE_LSB +: CODE_W];
  assign code_new  = wr_data[CODE_LSB +: CODE_W];
endmodule

// File: rtl/flagreg_unit_dec.sv
module flagreg_unit_dec #(
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned UNIT_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] code_cur,
  input  logic [CODE_W-1:0] code_new,
  output logic              nmi
);
  localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(UNIT_ID);

  logic hit;
  logic nmi_q;

  // edge on the field value, not on the write: same code again is silent
  assign hit = wr_en && (code_new == MY_CODE) && (code_cur != MY_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= hit;
  end

  assign nmi = nmi_q;
endmodule

// File: rtl/flagreg_ipi.sv
module flagreg_ipi
  import flagreg_pkg::*;
#(
  parameter int unsigned DATA_W    = FLAG_W_DEF,
  parameter int unsigned CODE_W    = CODE_W_DEF,
  parameter int unsigned CODE_LSB  = CODE_LSB_DEF,
  parameter int unsigned NUM_UNITS = UNITS_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_we,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_UNITS-1:0] ipi_nmi
);
  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;
  localparam int unsigned N_DEC    = (NUM_UNITS < MAX_CODE) ? NUM_UNITS : MAX_CODE;

  bus_op_e           op;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] flag_word;
  logic              wr_en;
  logic [CODE_W-1:0] code_cur;
  logic [CODE_W-1:0] code_new;

  flagreg_bus_port #(.DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .flag_word (flag_word),
    .op        (op),
    .wr_data   (wr_data)
  );

  flagreg_store #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .CODE_LSB (CODE_LSB)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .wr_data   (wr_data),
    .flag_word (flag_word),
    .wr_en     (wr_en),
    .code_cur  (code_cur),
    .code_new  (code_new)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    if (u < N_DEC) begin : g_dec
      flagreg_unit_dec #(
        .CODE_W  (CODE_W),
        .UNIT_ID (u + 1)
      ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .code_cur (code_cur),
        .code_new (code_new),
        .nmi      (ipi_nmi[u])
      );
    end else begin : g_none
      // no code can address this unit
      assign ipi_nmi[u] = 1'b0;
    end
  end
endmodule

// File: rtl/flagreg_ipi_chk.sv
module flagreg_ipi_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned CODE_LSB  = 13,
  parameter int unsigned NUM_UNITS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_we,
  input logic [DATA_W-1:0]    req_wdata,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic [NUM_UNITS-1:0] ipi_nmi,
  input logic [DATA_W-1:0]    flag_word
);
  logic wr_fire;
  assign wr_fire = req_valid && req_ready && req_we;

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n) wr_fire |=> flag_word == $past(req_wdata)); // R2
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R3
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |-> !req_ready); // R4
  AST_NMI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (|ipi_nmi) |-> $past(wr_fire)); // R5
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (|ipi_nmi) |=> ((ipi_nmi & $past(ipi_nmi)) == '0)); // R5
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n) (wr_fire && req_wdata[CODE_LSB +: CODE_W] == flag_word[CODE_LSB +: CODE_W]) |=> (ipi_nmi == '0)); // R6
  AST_NMI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ipi_nmi)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_fire |=> $stable(flag_word)); // R9

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_match
    AST_NMI_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) ipi_nmi[g] |-> (flag_word[CODE_LSB +: CODE_W] == CODE_W'(g + 1))); // R5
  end
endmodule

bind flagreg_ipi flagreg_ipi_chk #(
  .DATA_W    (DATA_W),
  .CODE_W    (CODE_W),
  .CODE_LSB  (CODE_LSB),
  .NUM_UNITS (NUM_UNITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .ipi_nmi   (ipi_nmi),
  .flag_word (flag_word)
);

// File: tb/flagreg_ipi_bench.sv
module flagreg_ipi_bench;
  localparam int NU = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic [NU-1:0] ipi_nmi;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  logic [NU-1:0] nmi_exp = '0;
  string nmi_tag = "R8";

  logic [15:0] q_data[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  flagreg_ipi u_flagreg_ipi (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .ipi_nmi   (ipi_nmi)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: read responses against the scoreboard, interrupt lines every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid && rsp_ready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R9 unexpected response", 32'(rsp_rdata), 32'hx);
        end else begin
          logic [15:0] e;
          string t;
          e = q_data.pop_front();
          t = q_tag.pop_front();
          check(rsp_rdata == e, t, 32'(rsp_rdata), 32'(e));
        end
      end
      if (nmi_exp != '0 || ipi_nmi != nmi_exp)
        check(ipi_nmi == nmi_exp, nmi_tag, 32'(ipi_nmi), 32'(nmi_exp));
    end
  end

  // inputs change 1 ns after the rising edge
  task automatic wr(input logic [15:0] d, input logic [NU-1:0] exp, input string tag);
    req_valid = 1'b1; req_we = 1'b1; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_we = 1'b0;
    nmi_exp = exp; nmi_tag = tag;
    @(posedge clk); #1;
    nmi_exp = '0; nmi_tag = "R5 single-cycle pulse";
  endtask

  task automatic rd(input logic [15:0] exp, input string tag);
    q_data.push_back(exp); q_tag.push_back(tag);
    req_valid = 1'b1; req_we = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    #4;
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    check(ipi_nmi == '0, "R1 ipi_nmi", 32'(ipi_nmi), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);
    rd(16'h0000, "R1 reset word");
    idle(1);

    wr(16'h2ABC, 7'b0000001, "R5 code 1 to unit 1");
    rd(16'h2ABC, "R2 readback");
    idle(1);
    wr(16'h2001, 7'b0000000, "R6 same code 1 rewritten");
    rd(16'h2001, "R2 readback other bits");
    idle(1);
    wr(16'h0000, 7'b0000000, "R7 clear to 000");
    rd(16'h0000, "R7 cleared word");
    idle(1);
    wr(16'hE123, 7'b1000000, "R5 code 7 to unit 7");
    wr(16'hA0F0, 7'b0010000, "R5 code 7 to 5");
    wr(16'h1FFF, 7'b0000000, "R7 code 000 with other bits set");
    rd(16'h1FFF, "R2 readback after clear");

    // R9: reads neither change the word nor fire interrupts
    rd(16'h1FFF, "R9 read 1");
    rd(16'h1FFF, "R9 read 2");
    idle(2);

    // R10: write data present while req_valid is low
    req_we = 1'b1; req_wdata = 16'h6000;
    idle(3);
    req_we = 1'b0;
    rd(16'h1FFF, "R10 word unchanged with valid low");
    idle(1);

    // R5 R8: walk every unit code in turn
    for (int k = 1; k <= NU; k++) begin
      wr(16'((k << 13) | k), NU'(1 << (k - 1)), $sformatf("R5 R8 walk code %0d", k));
    end
    wr(16'hE555, 7'b0000000, "R6 code 7 kept, low bits changed");
    rd(16'hE555, "R2 walk end word");

    // R3: back-to-back reads straddling a write
    rd(16'hE555, "R3 back-to-back 1");
    rd(16'hE555, "R3 back-to-back 2");
    wr(16'h4321, 7'b0000010, "R5 code 2 after reads");
    rd(16'h4321, "R3 read after write");
    idle(1);

    // R3 R4: stall the response
    rsp_ready = 1'b0;
    rd(16'h4321, "R3 stalled read data");
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(rsp_valid == 1'b1, "R3 rsp_valid held", 32'(rsp_valid), 1);
      check(rsp_rdata == 16'h4321, "R3 rsp_rdata held", 32'(rsp_rdata), 32'h4321);
      check(req_ready == 1'b0, "R4 req_ready low in stall", 32'(req_ready), 0);
      @(posedge clk); #1;
    end
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R4 req_ready while draining", 32'(req_ready), 1);
    idle(2);
    check(rsp_valid == 1'b0, "R3 response consumed", 32'(rsp_valid), 0);
    check(q_data.size() == 0, "R3 scoreboard empty", 32'(q_data.size()), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule